// File: doc/BRIEF.md
# Filter Configuration Host Port

This block is the host-facing configuration side of a multi-tap FIR engine. A host drives an 8-bit address, a 16-bit data bus, a target select, a chip select and a write enable. All of these are sampled on the system clock. Each write goes either to a 16-bit control word or to one entry of a 128-entry coefficient store. A write can be a single 16-bit word, or a pair of bytes presented low byte first. The filter datapath reads the coefficient store combinationally through its own read port.

The control word is double-buffered. A completed control write lands in a shadow copy. The copy the filter uses, exposed on `ctrl_word`, is refreshed from the shadow only when the coefficient bank changes. The one exception is the first control write after reset, which goes straight to the active copy.

The bank changes only on a sample strobe. The block produces this strobe by dividing the system clock by 1, 2, 4 or 8, as set by an active control field. The bank request comes from one of two places: an input pin, or a bit of the shadow word. The block can also be set to toggle the bank on every strobe. After reset the block reports busy for a fixed period, and all host writes are ignored during that period.

Top module: `filt_cfg_host_port`

## Requirements
- R1: While `rst_n` is low, `ctrl_word` reads 0x8C80, `bank_upper` and `rsv_flag` are 0, and `busy` is 1.
- R2: After `rst_n` rises, `busy` stays 1 for the first 21 rising clock edges and is 0 after the 22nd. It does not return to 1 without another reset.
- R3: A write happens only on an edge where both `host_cs_n` and `host_we_n` are 0. Every write presented while `busy` is 1 is discarded.
- R4: In word mode (`byte_mode`=0), `host_sel_ctl`=0 writes `host_data` into the coefficient entry indexed by `host_addr[6:0]`. `host_addr[7]` has no effect.
- R5: In byte mode (`byte_mode`=1), the byte on `host_data[7:0]` is taken as the low byte when `host_addr[0]`=0 and as the high byte when `host_addr[0]`=1. The coefficient index is `host_addr[7:1]`. A word completes only when a high byte follows a stored low byte; a high byte with no low byte before it is dropped.
- R6: The first control word completed after reset appears on `ctrl_word` one edge after the write.
- R7: For the two edges after a control word completes, every host write is discarded.
- R8: Any later control word is held in the shadow copy, and `ctrl_word` keeps its value until the bank changes.
- R9: `sample_tick` pulses once every 2^`ctrl_word[14:13]` clocks. `bank_upper` changes only on an edge where `sample_tick` is 1. When the bank changes, `ctrl_word` takes the shadow value.
- R10: When `ctrl_word[7]`=1 the bank request is bit 6 of the shadow word; when `ctrl_word[7]`=0 it is `swap_pin`. A request of 0 selects the lower bank (`bank_upper`=0) and a request of 1 selects the upper bank.
- R11: When `ctrl_word[5]`=1, `bank_upper` inverts on every sample strobe.
- R12: `rsv_flag` is 1 exactly when the last completed control word had a nonzero value in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| byte_mode | input | 1 | 1: byte-pair writes, 0: word writes |
| host_sel_ctl | input | 1 | 1: control word target, 0: coefficient target |
| host_cs_n | input | 1 | Active-low chip select |
| host_we_n | input | 1 | Active-low write enable |
| host_addr | input | 8 | Host address |
| host_data | input | 16 | Host write data |
| swap_pin | input | 1 | External bank request |
| coef_raddr | input | 7 | Coefficient read index |
| coef_rdata | output | 16 | Coefficient read data |
| ctrl_word | output | 16 | Active control word |
| bank_upper | output | 1 | 1 when the upper coefficient bank is in use |
| sample_tick | output | 1 | Sample strobe |
| busy | output | 1 | Post-reset busy indication |
| rsv_flag | output | 1 | Last control word had reserved bits set |

## Verification
The bench probes the exact edge where `busy` falls. A timer that is off by one would still show busy, or would already be idle, at the sampled edge. It also places a coefficient write in the cycle right after a control write. A design without the settle window would overwrite an entry that must keep its old value.

The bench checks that control words stay shadowed until a bank change. A design that loads the active word directly would change `ctrl_word` early. A design that never applies the direct first load after reset would keep the default word. Further checks cover both request sources, the auto-toggle mode, a lone high byte and the strobe period. These expose a wrong source choice, a bank that does not follow its source, or a divider with the wrong period.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned CFG_DW       = 16;
  localparam int unsigned CFG_AW       = 8;
  localparam int unsigned CFG_NCOEF    = 128;
  localparam int unsigned CFG_BUSY_CYC = 22;
  localparam int unsigned CFG_GUARD    = 2;
  localparam logic [CFG_DW-1:0] CFG_DEFAULT = 16'h8C80;

  // control word field positions
  localparam int unsigned F_DIV_LSB = 13;
  localparam int unsigned F_DIV_W   = 2;
  localparam int unsigned F_SRC_SEL = 7;
  localparam int unsigned F_SRC_BIT = 6;
  localparam int unsigned F_AUTO    = 5;
  localparam int unsigned F_RSV_W   = 4;
endpackage

// File: rtl/cfg_busy_timer.sv
module cfg_busy_timer #(
  parameter int unsigned CYCLES = 22
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R2: once idle, busy never returns without reset
  a_r2_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
endmodule

// File: rtl/cfg_write_decode.sv
module cfg_write_decode #(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 8,
  parameter int unsigned GUARD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          byte_mode,
  input  logic          sel_ctl,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          ctl_we,
  output logic          coef_we,
  output logic [AW-2:0] idx,
  output logic [DW-1:0] word
);
  localparam int unsigned HB = DW / 2;
  localparam int unsigned GW = $clog2(GUARD + 1);

  logic [HB-1:0] lo_q;
  logic          lo_ok_q;
  logic [GW-1:0] guard_q;
  logic          wr_ok, done;

  assign wr_ok = !cs_n && !we_n && !busy && (guard_q == '0);
  assign done  = wr_ok && (!byte_mode || (addr[0] && lo_ok_q));

  always_comb begin
    idx     = byte_mode ? addr[AW-1:1] : addr[AW-2:0];
    word    = byte_mode ? {data[HB-1:0], lo_q} : data;
    ctl_we  = done && sel_ctl;
    coef_we = done && !sel_ctl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      lo_ok_q <= 1'b0;
      guard_q <= '0;
    end else begin
      if (wr_ok && byte_mode) begin
        if (!addr[0]) begin
          lo_q    <= data[HB-1:0];
          lo_ok_q <= 1'b1;
        end else begin
          lo_ok_q <= 1'b0;
        end
      end
      if (ctl_we)              guard_q <= GW'(GUARD);
      else if (guard_q != '0)  guard_q <= guard_q - 1'b1;
    end
  end

  // R7: settle window after a control word
  a_r7_guard: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> !ctl_we && !coef_we);
  // R3: nothing gets through while busy
  a_r3_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ctl_we && !coef_we);
endmodule

// File: rtl/cfg_swap_ctrl.sv
module cfg_swap_ctrl
  import cfg_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] DEFAULT = 16'h8C80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [DW-1:0] wdata,
  input  logic          swap_pin,
  output logic [DW-1:0] active,
  output logic          bank,
  output logic          tick,
  output logic          rsv_flag
);
  localparam int unsigned CW = (1 << F_DIV_W) - 1;

  logic [DW-1:0]      shadow_q, active_q;
  logic               first_q, bank_q, rsv_q;
  logic [CW-1:0]      cnt_q, lim;
  logic [F_DIV_W-1:0] fld;
  logic               req, nxt_bank, direct;

  assign fld      = active_q[F_DIV_LSB +: F_DIV_W];
  assign lim      = CW'((32'd1 << fld) - 32'd1);
  assign tick     = (cnt_q >= lim);
  assign req      = active_q[F_SRC_SEL] ? shadow_q[F_SRC_BIT] : swap_pin;
  assign nxt_bank = active_q[F_AUTO] ? !bank_q : req;
  assign direct   = ctl_we && first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= DEFAULT;
      active_q <= DEFAULT;
      first_q  <= 1'b1;
      bank_q   <= 1'b0;
      rsv_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick && (nxt_bank != bank_q)) begin
        bank_q   <= nxt_bank;
        active_q <= shadow_q;
      end
      if (ctl_we) begin
        shadow_q <= wdata;
        rsv_q    <= |wdata[F_RSV_W-1:0];
        if (first_q) begin
          active_q <= wdata;
          first_q  <= 1'b0;
        end
      end
    end
  end

  assign active   = active_q;
  assign bank     = bank_q;
  assign rsv_flag = rsv_q;

  // R9: bank moves only on a strobe
  a_r9_bank_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> bank_q == $past(bank_q));
  // R8: active word held between swaps
  a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !direct) |=> $stable(active_q));
  // R11: auto mode flips the bank on each strobe
  a_r11_auto_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && active_q[F_AUTO] && !direct) |=> bank_q != $past(bank_q));
endmodule

// File: rtl/cfg_coef_store.sv
module cfg_coef_store #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/filt_cfg_host_port.sv
module filt_cfg_host_port
  import cfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_mode,
  input  logic                  host_sel_ctl,
  input  logic                  host_cs_n,
  input  logic                  host_we_n,
  input  logic [CFG_AW-1:0]     host_addr,
  input  logic [CFG_DW-1:0]     host_data,
  input  logic                  swap_pin,
  input  logic [CFG_AW-2:0]     coef_raddr,
  output logic [CFG_DW-1:0]     coef_rdata,
  output logic [CFG_DW-1:0]     ctrl_word,
  output logic                  bank_upper,
  output logic                  sample_tick,
  output logic                  busy,
  output logic                  rsv_flag
);
  logic              ctl_we, coef_we;
  logic [CFG_AW-2:0] widx;
  logic [CFG_DW-1:0] wword;

  cfg_busy_timer #(.CYCLES(CFG_BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .busy(busy)
  );

  cfg_write_decode #(.DW(CFG_DW), .AW(CFG_AW), .GUARD(CFG_GUARD)) u_dec (
    .clk(clk), .rst_n(rst_n), .busy(busy), .byte_mode(byte_mode),
    .sel_ctl(host_sel_ctl), .cs_n(host_cs_n), .we_n(host_we_n),
    .addr(host_addr), .data(host_data), .ctl_we(ctl_we),
    .coef_we(coef_we), .idx(widx), .word(wword)
  );

  cfg_swap_ctrl #(.DW(CFG_DW), .DEFAULT(CFG_DEFAULT)) u_swap (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wdata(wword),
    .swap_pin(swap_pin), .active(ctrl_word), .bank(bank_upper),
    .tick(sample_tick), .rsv_flag(rsv_flag)
  );

  cfg_coef_store #(.DW(CFG_DW), .DEPTH(CFG_NCOEF)) u_mem (
    .clk(clk), .we(coef_we), .waddr(widx), .wdata(wword),
    .raddr(coef_raddr), .rdata(coef_rdata)
  );

  // R3: a coefficient write needs both strobes low
  a_r3_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs_n || host_we_n) |-> !coef_we && !ctl_we);
endmodule

// File: tb/filt_cfg_host_port_test.sv
module filt_cfg_host_port_test;
  logic clk = 0;
  logic rst_n = 0;
  logic byte_mode = 0, host_sel_ctl = 0, host_cs_n = 1, host_we_n = 1;
  logic [7:0] host_addr = '0;
  logic [15:0] host_data = '0;
  logic swap_pin = 0;
  logic [6:0] coef_raddr = '0;
  logic [15:0] coef_rdata, ctrl_word;
  logic bank_upper, sample_tick, busy, rsv_flag;

  int nchk = 0, nfail = 0;
  string rq_q[$];
  logic [15:0] v_q[$];

  always #5 clk = ~clk;

  filt_cfg_host_port uut (.*);

  task automatic push(input string rq, input logic [15:0] v);
    rq_q.push_back(rq);
    v_q.push_back(v);
  endtask

  task automatic pop_cmp(input logic [15:0] act);
    string rq;
    logic [15:0] v;
    rq = rq_q.pop_front();
    v  = v_q.pop_front();
    nchk++;
    if (act !== v) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, v);
    end
  endtask

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] v);
    push(rq, v);
    pop_cmp(act);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] a, input logic [15:0] d);
    host_sel_ctl = sel; host_addr = a; host_data = d;
    host_cs_n = 0; host_we_n = 0;
    @(negedge clk);
    host_cs_n = 1; host_we_n = 1;
  endtask

  task automatic rd_cmp(input string rq, input logic [6:0] i);
    coef_raddr = i;
    #1 pop_cmp(coef_rdata);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int ticks;
    logic b0;
    // R1 reset state
    idle(20);
    chk("R1 ctrl default", ctrl_word, 16'h8C80);
    chk("R1 bank", {15'd0, bank_upper}, 16'd0);
    chk("R1 flag", {15'd0, rsv_flag}, 16'd0);
    chk("R1 busy", {15'd0, busy}, 16'd1);
    rst_n = 1;
    // R2 busy window; R3 write during busy dropped
    for (int k = 1; k <= 22; k++) begin
      if (k == 5) begin
        host_sel_ctl = 1; host_data = 16'h1234; host_cs_n = 0; host_we_n = 0;
      end else begin
        host_cs_n = 1; host_we_n = 1;
      end
      @(negedge clk);
      if (k == 21) chk("R2 busy at 21", {15'd0, busy}, 16'd1);
      if (k == 22) chk("R2 idle at 22", {15'd0, busy}, 16'd0);
    end
    chk("R3 busy write ignored", ctrl_word, 16'h8C80);
    // R4 word mode, addr bit 7 ignored
    wr(0, 8'h85, 16'hA5A5); push("R4 idx5", 16'hA5A5);
    wr(0, 8'h1E, 16'h5555); push("R4 idx30", 16'h5555);
    rd_cmp("R4", 7'd5); rd_cmp("R4", 7'd30);
    // R3 cs without we: no write
    host_sel_ctl = 0; host_addr = 8'h05; host_data = 16'h0BAD;
    host_cs_n = 0; host_we_n = 1; @(negedge clk); host_cs_n = 1;
    push("R3 we high", 16'hA5A5); rd_cmp("R3", 7'd5);
    // R5 byte mode
    byte_mode = 1;
    wr(0, 8'h14, 16'h0034); wr(0, 8'h15, 16'h0012);
    push("R5 byte pair", 16'h1234); rd_cmp("R5", 7'd10);
    byte_mode = 0; wr(0, 8'h14, 16'h7777); byte_mode = 1;
    wr(0, 8'h29, 16'h00EE);
    push("R5 lone high", 16'h7777); rd_cmp("R5", 7'd20);
    byte_mode = 0;
    // R6 direct first load, R7 guard
    host_sel_ctl = 1; host_data = 16'hAC80; host_cs_n = 0; host_we_n = 0;
    @(negedge clk);
    chk("R6 direct load", ctrl_word, 16'hAC80);
    host_sel_ctl = 0; host_addr = 8'h1E; host_data = 16'h1234;
    @(negedge clk);
    host_cs_n = 1; host_we_n = 1;
    push("R7 guarded write", 16'h5555); rd_cmp("R7", 7'd30);
    idle(2);
    wr(0, 8'h1E, 16'h1234); push("R7 after guard", 16'h1234); rd_cmp("R7", 7'd30);
    // R8 shadow hold
    wr(1, 8'h00, 16'hCC80); idle(8);
    chk("R8 held", ctrl_word, 16'hAC80);
    // R10 register source high -> upper; R9 within period
    wr(1, 8'h00, 16'hCCC0); idle(4);
    chk("R10 upper bank", {15'd0, bank_upper}, 16'd1);
    chk("R9 swap loads shadow", ctrl_word, 16'hCCC0);
    wr(1, 8'h00, 16'h8C40); idle(10);
    chk("R8 no swap no load", ctrl_word, 16'hCCC0);
    swap_pin = 0;
    wr(1, 8'h00, 16'h8C00); idle(6);
    chk("R10 lower bank", {15'd0, bank_upper}, 16'd0);
    chk("R10 active", ctrl_word, 16'h8C00);
    // R10 pin source, R9 divide-by-1
    swap_pin = 1; @(negedge clk);
    chk("R9 pin swap next edge", {15'd0, bank_upper}, 16'd1);
    // R11 auto toggle
    wr(1, 8'h00, 16'h8C20); idle(3);
    chk("R8 held pin mode", ctrl_word, 16'h8C00);
    swap_pin = 0; @(negedge clk);
    chk("R11 activated", ctrl_word, 16'h8C20);
    b0 = bank_upper; @(negedge clk);
    chk("R11 flip1", {15'd0, bank_upper}, {15'd0, ~b0});
    @(negedge clk);
    chk("R11 flip2", {15'd0, bank_upper}, {15'd0, b0});
    // R12 reserved bits via byte control write
    byte_mode = 1;
    wr(1, 8'h00, 16'h0025); wr(1, 8'h01, 16'h008C);
    chk("R12 flag set", {15'd0, rsv_flag}, 16'd1);
    byte_mode = 0; idle(3);
    wr(1, 8'h00, 16'h8C20);
    chk("R12 flag clear", {15'd0, rsv_flag}, 16'd0);
    // R9 divide-by-8 period
    idle(3);
    wr(1, 8'h00, 16'hE020); idle(4);
    chk("R9 active div8", ctrl_word, 16'hE020);
    ticks = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (sample_tick) ticks++;
    end
    chk("R9 tick count", 16'(ticks), 16'd4);
    finish_run();
  end
endmodule